// File: doc/BRIEF.md
# Two-Level Bus Arbiter with Stalled-Master Masking

This block is the central arbiter of a shared PCI-style bus with eight request ports. Each physical port is mapped by configuration to one of eight arbitration positions. Positions A to D form the upper level. Positions W to Z form the lower level, and the lower level as a whole takes one slot in the upper level. The upper level rotates among its five slots. The lower level gives first place to W after reset. It then gives first place to its most recent winner, or always to W when fixed-park mode is selected. When no port is requesting, the grant parks on the lower level's first-place master.

The arbiter samples FRAME# and IRDY# and changes the grant only on an idle bus. It keeps a granted master until that master withdraws its request. With detection enabled, a master that wins the bus and does not drive FRAME# within a fixed window is marked broken. A broken master is left out of arbitration until software clears its status bit. The window restarts on every grant, so only the master that held the grant when the window ran out is ever marked.

Top module: `twoLevelArbiter`

## Requirements
- R1: While reset is asserted, all grant outputs are deasserted (high) and all broken-status bits are 0. In the first cycle after reset the grant parks on position W.
- R2: Port p takes its position from the 3-bit field `cfgPortMap[3p+2:3p]`. Codes 0 to 3 are upper-level positions A to D, and codes 4 to 7 are lower-level positions W to Z. Codes are unique across ports.
- R3: At most one `gntN` bit is low (active) at any time. A new grant appears one clock after the cycle in which it was decided.
- R4: The grant changes only after a clock edge at which FRAME# and IRDY# were both sampled high, and only once the current winner no longer requests.
- R5: The upper level rotates among slots A, B, C, D and the lower-level slot, in that order. After each win the first-place slot becomes the one after the winner. After reset, A is in first place.
- R6: Within the lower level, with fixed-park mode off, W is first after reset and the most recent lower-level winner is first afterwards. With fixed-park mode on, W is always first. The order of the lower level is W, X, Y, Z, cyclic.
- R7: When no port has an active, unmasked request on an idle bus, the grant parks on the lower level's first-place master.
- R8: With `cfgDetectEn` = 1, a master that won the grant and keeps requesting gets its status bit set on the 16th clock edge after the grant edge, unless FRAME# was sampled low at one of those 16 edges. With `cfgDetectEn` = 0, no status bit is ever set.
- R9: A port whose status bit is set is treated as not requesting. Its grant is withdrawn at the next idle edge.
- R10: The timeout count restarts on every new grant. A master that is granted after a broken master and starts at the 16th edge is not marked.
- R11: Writing 1 to bit p of `brokenClr` clears status bit p at the next clock edge. Once cleared, the port can win again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqN | input | 8 | Active-low request, one per physical port |
| frameN | input | 1 | Bus FRAME#, active low |
| irdyN | input | 1 | Bus IRDY#, active low |
| cfgPortMap | input | 24 | Position code, 3 bits per port |
| cfgDetectEn | input | 1 | Enables broken-master detection |
| cfgFixedPark | input | 1 | Keeps W in first place of the lower level |
| brokenClr | input | 8 | Write-one-to-clear pulses for status bits |
| gntN | output | 8 | Active-low one-hot grant |
| brokenStat | output | 8 | Broken-master status, one bit per port |

## Verification
A grant decided at an idle edge shows on `gntN` after that one edge. A status bit shows after the 16th edge that follows the grant edge, and a clear shows after one edge. A masked master's grant moves one edge after its status bit sets. The bench changes every input on the falling clock edge. It compares outputs on the next falling edge, after it has counted exactly the rising edges that these latencies require. The timeout cases are sampled at edge 15 and edge 16 around the boundary. The next master starts exactly at its 16th edge, which catches a counter that is not restarted.

// File: rtl/arbPkg.sv
package arbPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;       // re-arbitrate at this edge
    logic flagOwner;  // mark the current owner broken
  } arbStrobe_t;
endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_PORTS-1:0]                   reqN,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] cfgPortMap,
  input  logic                                   cfgFixedPark,
  input  logic [NUM_PORTS-1:0]                   brokenClr,
  input  arbStrobe_t                             strobe,
  output logic [NUM_PORTS-1:0]                   gntN,
  output logic [NUM_PORTS-1:0]                   brokenStat,
  output logic                                   ownerHold
);
  localparam int PW    = $clog2(NUM_PORTS);
  localparam int HALF  = NUM_PORTS / 2;
  localparam int SLOTS = HALF + 1;
  localparam int SW    = $clog2(SLOTS);
  localparam int LW    = $clog2(HALF);

  logic [PW-1:0]        ownerPort;
  logic                 ownerValid, ownerWon;
  logic [SW-1:0]        hiPtr;
  logic [LW-1:0]        loPtr;
  logic [NUM_PORTS-1:0] broken;

  logic [NUM_PORTS-1:0] effReq;
  logic [NUM_PORTS-1:0] posReq, posMapped;
  logic [PW-1:0]        posPort [NUM_PORTS];
  logic [LW-1:0]        loHead, loWin;
  logic                 loHit;
  logic [SLOTS-1:0]     hiVec;
  logic [SW-1:0]        hiWin;
  logic                 hiHit;
  logic [PW-1:0]        winPos, parkPos;
  logic                 parkOk;

  assign effReq = ~reqN & ~broken;

  // port-to-position mapping
  always_comb begin
    posReq    = '0;
    posMapped = '0;
    for (int q = 0; q < NUM_PORTS; q++) posPort[q] = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      posReq[cfgPortMap[p*PW +: PW]]    = posReq[cfgPortMap[p*PW +: PW]] | effReq[p];
      posMapped[cfgPortMap[p*PW +: PW]] = 1'b1;
      posPort[cfgPortMap[p*PW +: PW]]   = PW'(p);
    end
  end

  // lower-level rotating pick
  assign loHead = cfgFixedPark ? '0 : loPtr;
  always_comb begin
    loHit = 1'b0;
    loWin = '0;
    for (int i = 0; i < HALF; i++) begin
      if (!loHit && posReq[HALF + ((int'(loHead) + i) % HALF)]) begin
        loHit = 1'b1;
        loWin = LW'((int'(loHead) + i) % HALF);
      end
    end
  end

  // upper-level rotating pick, lower level as last slot
  assign hiVec = {loHit, posReq[HALF-1:0]};
  always_comb begin
    hiHit = 1'b0;
    hiWin = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!hiHit && hiVec[(int'(hiPtr) + i) % SLOTS]) begin
        hiHit = 1'b1;
        hiWin = SW'((int'(hiPtr) + i) % SLOTS);
      end
    end
  end

  assign winPos  = (int'(hiWin) == HALF) ? PW'(HALF + int'(loWin)) : PW'(hiWin);
  assign parkPos = PW'(HALF + int'(loHead));
  assign parkOk  = posMapped[parkPos] & ~broken[posPort[parkPos]];

  assign ownerHold = ownerValid & ownerWon & effReq[ownerPort];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerPort  <= '0;
      ownerValid <= 1'b0;
      ownerWon   <= 1'b0;
      hiPtr      <= '0;
      loPtr      <= '0;
      broken     <= '0;
    end else begin
      if (strobe.load) begin
        if (hiHit) begin
          ownerPort  <= posPort[winPos];
          ownerValid <= 1'b1;
          ownerWon   <= 1'b1;
          hiPtr      <= (int'(hiWin) == SLOTS-1) ? '0 : hiWin + 1'b1;
          if (int'(hiWin) == HALF && !cfgFixedPark) loPtr <= loWin;
        end else if (parkOk) begin
          ownerPort  <= posPort[parkPos];
          ownerValid <= 1'b1;
          ownerWon   <= 1'b0;
        end else begin
          ownerValid <= 1'b0;
          ownerWon   <= 1'b0;
        end
      end
      broken <= (broken & ~brokenClr) |
                (strobe.flagOwner ? (NUM_PORTS'(1) << ownerPort) : '0);
    end
  end

  always_comb begin
    gntN = '1;
    if (ownerValid) gntN[ownerPort] = 1'b0;
  end

  assign brokenStat = broken;
endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       cfgDetectEn,
  input  logic       ownerHold,
  output arbStrobe_t strobe
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

  logic [CW-1:0] waitCnt;
  logic          started;
  logic          busIdle, waiting, expire;

  assign busIdle = frameN & irdyN;
  assign waiting = ownerHold & ~started & frameN;
  assign expire  = waiting & (waitCnt == CW'(TIMEOUT_CYCLES - 1));

  assign strobe.load      = busIdle & ~ownerHold;
  assign strobe.flagOwner = expire & cfgDetectEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      started <= 1'b0;
    end else if (strobe.load) begin
      waitCnt <= '0;
      started <= 1'b0;
    end else if (ownerHold && !frameN) begin
      started <= 1'b1;
    end else if (waiting && !expire) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/twoLevelArbiter.sv
module twoLevelArbiter
  import arbPkg::*;
#(
  parameter int NUM_PORTS      = 8,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_PORTS-1:0]                   reqN,
  input  logic                                   frameN,
  input  logic                                   irdyN,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] cfgPortMap,
  input  logic                                   cfgDetectEn,
  input  logic                                   cfgFixedPark,
  input  logic [NUM_PORTS-1:0]                   brokenClr,
  output logic [NUM_PORTS-1:0]                   gntN,
  output logic [NUM_PORTS-1:0]                   brokenStat
);
  arbStrobe_t strobe;
  logic       ownerHold;

  arbControl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .cfgDetectEn(cfgDetectEn), .ownerHold(ownerHold), .strobe(strobe)
  );

  arbDatapath #(.NUM_PORTS(NUM_PORTS)) dp (
    .clk(clk), .rstN(rstN), .reqN(reqN), .cfgPortMap(cfgPortMap),
    .cfgFixedPark(cfgFixedPark), .brokenClr(brokenClr), .strobe(strobe),
    .gntN(gntN), .brokenStat(brokenStat), .ownerHold(ownerHold)
  );
endmodule

// File: rtl/twoLevelArbiterChecker.sv
module twoLevelArbiterChecker #(
  parameter int NUM_PORTS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameN,
  input logic                 irdyN,
  input logic                 cfgDetectEn,
  input logic [NUM_PORTS-1:0] gntN,
  input logic [NUM_PORTS-1:0] brokenStat
);
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  a_r4_change_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gntN) |-> $past(frameN && irdyN));

  a_r10_flag_only_holder: assert property (@(posedge clk) disable iff (!rstN)
    (|(brokenStat & ~$past(brokenStat))) |->
      ((brokenStat & ~$past(brokenStat) & $past(gntN)) == '0));

  a_r8_no_flag_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgDetectEn) |-> ((brokenStat & ~$past(brokenStat)) == '0));

  a_r9_masked_not_granted: assert property (@(posedge clk) disable iff (!rstN)
    ((~gntN & $past(gntN) & $past(brokenStat)) == '0));
endmodule

bind twoLevelArbiter twoLevelArbiterChecker #(.NUM_PORTS(NUM_PORTS)) chk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
  .cfgDetectEn(cfgDetectEn), .gntN(gntN), .brokenStat(brokenStat)
);

// File: tb/twoLevelArbiter_test.sv
module twoLevelArbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqN = '1;
  logic       frameN = 1'b1, irdyN = 1'b1;
  logic [23:0] cfgPortMap;
  logic       cfgDetectEn = 1'b0, cfgFixedPark = 1'b0;
  logic [7:0] brokenClr = '0;
  logic [7:0] gntN, brokenStat;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoLevelArbiter uut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .frameN(frameN), .irdyN(irdyN),
    .cfgPortMap(cfgPortMap), .cfgDetectEn(cfgDetectEn),
    .cfgFixedPark(cfgFixedPark), .brokenClr(brokenClr),
    .gntN(gntN), .brokenStat(brokenStat)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] grantOf(int port);
    return ~(8'b1 << port);
  endfunction

  function automatic logic [23:0] makeMap(bit swapped);
    logic [23:0] m;
    for (int p = 0; p < 8; p++) m[p*3 +: 3] = 3'(p);
    if (swapped) begin
      m[0*3 +: 3] = 3'd7; m[7*3 +: 3] = 3'd0;
      m[3*3 +: 3] = 3'd4; m[4*3 +: 3] = 3'd3;
    end
    return m;
  endfunction

  task automatic doReset(bit swapped, bit detect, bit fixedPark);
    rstN = 1'b0; reqN = '1; frameN = 1'b1; irdyN = 1'b1; brokenClr = '0;
    cfgPortMap = makeMap(swapped); cfgDetectEn = detect; cfgFixedPark = fixedPark;
    tick(2);
    check("R1", gntN, 8'hFF, "grant during reset");
    check("R1", brokenStat, 8'h00, "status during reset");
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hp, k;
    logic [7:0] r;
    bit found;

    // R1, R7: park on W after reset
    doReset(0, 0, 0);
    check("R1", gntN, grantOf(4), "park on W after reset");

    // R5, R7: sweep all request mixes of A..D and W
    hp = 0;
    for (int m = 1; m < 32; m++) begin
      r = '0;
      r[4:0] = 5'(m);
      reqN = ~r;
      tick();
      found = 0; k = 0;
      for (int i = 0; i < 5; i++)
        if (!found && r[(hp + i) % 5]) begin found = 1; k = (hp + i) % 5; end
      check("R5", gntN, grantOf(k), $sformatf("rotation mask %0d", m));
      hp = (k + 1) % 5;
      reqN = '1;
      tick();
      check("R7", gntN, grantOf(4), "park after release");
    end

    // R4: grant held while bus busy
    reqN = 8'b1111_1110; tick();
    check("R4", gntN, grantOf(0), "lone requester wins");
    frameN = 1'b0; reqN = 8'b1111_1101;
    tick(3);
    check("R4", gntN, grantOf(0), "held while FRAME# low");
    frameN = 1'b1; irdyN = 1'b0; tick();
    check("R4", gntN, grantOf(0), "held while IRDY# low");
    irdyN = 1'b1; tick();
    check("R4", gntN, grantOf(1), "moves on idle bus");
    reqN = '1; tick();

    // R6, R7: lower level ordering, moving then fixed
    reqN = ~8'b1010_0000; tick();
    check("R6", gntN, grantOf(5), "X after W first");
    reqN = '1; tick();
    check("R6", gntN, grantOf(5), "park on last lower winner X");
    reqN = ~8'b0101_0000; tick();
    check("R6", gntN, grantOf(6), "Y after X first");
    reqN = '1; tick();
    check("R7", gntN, grantOf(6), "park on Y");
    cfgFixedPark = 1'b1; tick();
    check("R6", gntN, grantOf(4), "fixed mode parks on W");
    reqN = ~8'b1010_0000; tick();
    check("R6", gntN, grantOf(5), "fixed mode X wins from W");
    reqN = '1; tick();
    check("R6", gntN, grantOf(4), "fixed mode park W again");

    // R8, R9, R10, R11: timeout on A, W follows
    doReset(0, 1, 0);
    reqN = ~8'b0001_0001; tick();
    check("R8", gntN, grantOf(0), "A granted");
    tick(15);
    check("R8", brokenStat, 8'h00, "not flagged at edge 15");
    tick();
    check("R8", brokenStat, 8'h01, "flagged at edge 16");
    check("R9", gntN, grantOf(0), "grant still on A at flag edge");
    tick();
    check("R9", gntN, grantOf(4), "W granted after masking A");
    tick(15);
    frameN = 1'b0; tick();
    check("R10", brokenStat, 8'h01, "W starting at edge 16 not flagged");
    frameN = 1'b1; reqN = ~8'b0000_0001; tick(3);
    check("R9", gntN, grantOf(4), "masked A ignored, park W");
    check("R10", brokenStat, 8'h01, "only A flagged");
    brokenClr = 8'h01; tick(); brokenClr = '0;
    check("R11", brokenStat, 8'h00, "clear A");
    tick();
    check("R11", gntN, grantOf(0), "A wins after clear");
    reqN = '1; tick();

    // R8: detection off
    doReset(0, 0, 0);
    reqN = ~8'b0000_0100; tick();
    check("R8", gntN, grantOf(2), "C granted");
    tick(40);
    check("R8", brokenStat, 8'h00, "no flag with detection off");
    check("R8", gntN, grantOf(2), "C still holds");
    reqN = '1; tick();

    // R2: remapped ports
    doReset(1, 0, 0);
    check("R2", gntN, grantOf(3), "W on port 3 parks");
    reqN = ~8'b1000_0001; tick();
    check("R2", gntN, grantOf(7), "A on port 7 beats Z on port 0");
    reqN = '1; tick();
    check("R2", gntN, grantOf(3), "park back on port 3");
    reqN = ~8'b0000_0001; tick();
    check("R2", gntN, grantOf(0), "Z on port 0 wins alone");
    reqN = '1; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule